// File: doc/BRIEF.md
# Predicated Whole-Vector Carry Shifter

This unit shifts a 128-bit vector left as if it were one long word. The vector is split into four 32-bit lanes. Bits for the bottom of each lane come from a running 32-bit carry. That carry starts as the value of a scalar register. The top bits each lane pushes out become the carry for the next lane up. The carry left after the top lane is returned so it can be written back to the scalar register. The shift amount comes from a 5-bit immediate, where the value zero means a full 32-bit shift.

A 16-bit byte predicate controls the result, with one bit per destination byte. A byte takes its shifted value only where its bit is set and keeps its old contents otherwise. The lowest predicate bit of each lane's group of four decides whether that lane's shifted-out bits replace the running carry. An operand check rejects scalar register indices 13 and 15. For those it raises a flag and returns the vector and the scalar unchanged.

The four-lane chain is combinational. A start strobe captures a result into output registers, and a done strobe follows one cycle later. The outputs hold their value until the next start.

Top module: `vec_carry_shifter`

## Requirements
- R1: For each lane with shift amount N (1..31), the shifted lane value is the old lane shifted left by N, with its low N bits filled from the low N bits of the current carry.
- R2: Lanes are processed from lane 0 (bits 31:0) up to lane 3 (bits 127:96). When predicate bit 4e is 1, lane e replaces the carry with its top N bits, which equal the old lane value shifted right by 32-N.
- R3: When predicate bit 4e is 0, lane e passes the carry it received on to the next lane unchanged, even if some of its bytes are written.
- R4: A shift immediate of 0 is a 32-bit shift. The lane's shifted value is the whole current carry, and, when bit 4e is 1, the old lane value becomes the new carry.
- R5: Destination byte b (bits 8b+7:8b) takes the shifted value when predicate bit b is 1 and keeps the input byte when it is 0.
- R6: The carry remaining after lane 3 appears on carry_o.
- R7: A scalar register index of 13 or 15 sets illegal_o. In that case vec_o equals vec_i and carry_o equals carry_i. Any other index clears illegal_o.
- R8: done_o is high exactly in the cycle after a cycle with start_i high. vec_o, carry_o and illegal_o change only on such a start and otherwise hold their values.
- R9: With the predicate all ones and a shift immediate of 0, the result is a 160-bit rotate of {vec, carry} by 32 bits: vec_o = {vec_i[95:0], carry_i} and carry_o = vec_i[127:96].
- R10: With the predicate all zeros, vec_o equals vec_i and carry_o equals carry_i.
- R11: After reset, vec_o, carry_o, done_o and illegal_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Captures one operation |
| vec_i | input | 128 | Vector operand, lane 0 in the low bits |
| carry_i | input | 32 | Scalar carry-in value |
| shamt_i | input | 5 | Shift immediate, 0 means 32 |
| ridx_i | input | 4 | Scalar register index, checked for legality |
| bmask_i | input | 16 | Byte predicate, bit b for byte b |
| vec_o | output | 128 | Merged result vector |
| carry_o | output | 32 | Updated scalar value |
| done_o | output | 1 | High one cycle after start |
| illegal_o | output | 1 | Last operation used a rejected index |

## Verification
The sweeps cover every shift immediate against masks that set or clear only the carry-gating bit of a lane. A design that gated the carry with the wrong bit of the group, or with any byte written, would send the wrong carry up the chain. The zero immediate is tested on its own, because a design that took it as no shift would return the lane unchanged instead of the carry. Pseudo-random byte masks catch merges done per lane rather than per byte. All sixteen register indices are run, so a decoder that missed 13 or 15, or also rejected 14, shows up at once.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
    localparam int DEF_LANE_W = 32;
    localparam int DEF_LANES  = 4;
    localparam int BYTE_W     = 8;
endpackage

// File: rtl/vcs_lane.sv
module vcs_lane import vcs_pkg::*; #(
    parameter  int LANE_W = DEF_LANE_W,
    parameter  int SH_W   = $clog2(LANE_W),
    localparam int NBYTES = LANE_W / BYTE_W,
    localparam int AMT_W  = SH_W + 1
) (
    input  logic [LANE_W-1:0] lane_i,
    input  logic [LANE_W-1:0] cin_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [NBYTES-1:0] bmask_i,
    output logic [LANE_W-1:0] lane_o,
    output logic [LANE_W-1:0] cout_o
);
    logic [AMT_W-1:0]    amt;
    logic [2*LANE_W-1:0] wide;
    logic [2*LANE_W-1:0] fillm;
    logic [LANE_W-1:0]   shifted;
    logic [LANE_W-1:0]   spill;

    always_comb begin
        // a zero immediate selects the full lane width
        amt     = (shamt_i == '0) ? AMT_W'(LANE_W) : {1'b0, shamt_i};
        wide    = {{LANE_W{1'b0}}, lane_i} << amt;
        fillm   = ({{(2*LANE_W-1){1'b0}}, 1'b1} << amt) - 1'b1;
        shifted = wide[LANE_W-1:0] | (cin_i & fillm[LANE_W-1:0]);
        spill   = wide[2*LANE_W-1:LANE_W];
        cout_o  = bmask_i[0] ? spill : cin_i;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign lane_o[b*BYTE_W +: BYTE_W] = bmask_i[b] ? shifted[b*BYTE_W +: BYTE_W]
                                                       : lane_i[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/vcs_opcheck.sv
module vcs_opcheck #(
    parameter int IDX_W     = 4,
    parameter int BAD_IDX_A = 13,
    parameter int BAD_IDX_B = 15
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             bad_o
);
    assign bad_o = (idx_i == IDX_W'(BAD_IDX_A)) || (idx_i == IDX_W'(BAD_IDX_B));
endmodule

// File: rtl/vec_carry_shifter.sv
module vec_carry_shifter import vcs_pkg::*; #(
    parameter  int LANE_W    = DEF_LANE_W,
    parameter  int LANES     = DEF_LANES,
    parameter  int IDX_W     = 4,
    parameter  int BAD_IDX_A = 13,
    parameter  int BAD_IDX_B = 15,
    localparam int VEC_W     = LANE_W * LANES,
    localparam int MASK_W    = VEC_W / BYTE_W,
    localparam int LMASK_W   = LANE_W / BYTE_W,
    localparam int SH_W      = $clog2(LANE_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [LANE_W-1:0] carry_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [IDX_W-1:0]  ridx_i,
    input  logic [MASK_W-1:0] bmask_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic [LANE_W-1:0] carry_o,
    output logic              done_o,
    output logic              illegal_o
);
    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [LANE_W-1:0] carry;
        logic              done;
        logic              illegal;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [LANE_W-1:0] chain [LANES+1];
    logic [VEC_W-1:0]  merged;
    logic              bad_idx;

    assign chain[0] = carry_i;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        vcs_lane #(
            .LANE_W (LANE_W),
            .SH_W   (SH_W)
        ) u_lane (
            .lane_i  (vec_i[e*LANE_W +: LANE_W]),
            .cin_i   (chain[e]),
            .shamt_i (shamt_i),
            .bmask_i (bmask_i[e*LMASK_W +: LMASK_W]),
            .lane_o  (merged[e*LANE_W +: LANE_W]),
            .cout_o  (chain[e+1])
        );
    end

    vcs_opcheck #(
        .IDX_W     (IDX_W),
        .BAD_IDX_A (BAD_IDX_A),
        .BAD_IDX_B (BAD_IDX_B)
    ) u_opcheck (
        .idx_i (ridx_i),
        .bad_o (bad_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.done    = 1'b1;
            st_d.illegal = bad_idx;
            if (bad_idx) begin
                st_d.vec   = vec_i;
                st_d.carry = carry_i;
            end else begin
                st_d.vec   = merged;
                st_d.carry = chain[LANES];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vec_o     = st_q.vec;
    assign carry_o   = st_q.carry;
    assign done_o    = st_q.done;
    assign illegal_o = st_q.illegal;
endmodule

// File: rtl/vcs_checker.sv
module vcs_checker #(
    parameter  int LANE_W = 32,
    parameter  int LANES  = 4,
    parameter  int IDX_W  = 4,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int MASK_W = VEC_W / 8,
    localparam int SH_W   = $clog2(LANE_W)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [VEC_W-1:0]  vec_i,
    input logic [LANE_W-1:0] carry_i,
    input logic [SH_W-1:0]   shamt_i,
    input logic [IDX_W-1:0]  ridx_i,
    input logic [MASK_W-1:0] bmask_i,
    input logic [VEC_W-1:0]  vec_o,
    input logic [LANE_W-1:0] carry_o,
    input logic              done_o,
    input logic              illegal_o
);
    logic rejected;
    assign rejected = (ridx_i == IDX_W'(13)) || (ridx_i == IDX_W'(15));

    // R8
    done_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> done_o);

    // R8
    no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> (!done_o && $stable(vec_o) && $stable(carry_o) && $stable(illegal_o)));

    // R7
    reject_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && rejected) |=>
        (illegal_o && vec_o == $past(vec_i) && carry_o == $past(carry_i)));

    // R7
    legal_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !rejected) |=> !illegal_o);

    // R10
    empty_mask_ident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && bmask_i == '0) |=>
        (vec_o == $past(vec_i) && carry_o == $past(carry_i)));

    // R9
    full_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !rejected && bmask_i == '1 && shamt_i == '0) |=>
        (vec_o == {$past(vec_i[VEC_W-LANE_W-1:0]), $past(carry_i)} &&
         carry_o == $past(vec_i[VEC_W-1:VEC_W-LANE_W])));
endmodule

bind vec_carry_shifter vcs_checker #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .IDX_W  (IDX_W)
) u_vcs_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .vec_i     (vec_i),
    .carry_i   (carry_i),
    .shamt_i   (shamt_i),
    .ridx_i    (ridx_i),
    .bmask_i   (bmask_i),
    .vec_o     (vec_o),
    .carry_o   (carry_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
);

// File: tb/tb_vec_carry_shifter.sv
module tb_vec_carry_shifter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] vin = '0;
    logic [31:0]  cin = '0;
    logic [4:0]   sh = '0;
    logic [3:0]   idx = '0;
    logic [15:0]  msk = '0;
    logic [127:0] vout;
    logic [31:0]  cout;
    logic         done;
    logic         illegal;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vec_carry_shifter dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vec_i(vin), .carry_i(cin),
        .shamt_i(sh), .ridx_i(idx), .bmask_i(msk), .vec_o(vout), .carry_o(cout),
        .done_o(done), .illegal_o(illegal)
    );

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [127:0] rnd128();
        return {rnd(), rnd(), rnd(), rnd()};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result built lane by lane from the written requirements
    task automatic model(input logic [127:0] v, input logic [31:0] c, input logic [4:0] s,
                         input logic [15:0] m, output logic [127:0] vr, output logic [31:0] cr);
        int k;
        logic [31:0] lane, res, top;
        k  = (s == 0) ? 32 : int'(s);
        vr = v;
        for (int e = 0; e < 4; e++) begin
            lane = v[32*e +: 32];
            if (k == 32) begin
                res = c;
                top = lane;
            end else begin
                res = (lane << k) | (c & ((32'h1 << k) - 32'h1));
                top = lane >> (32 - k);
            end
            for (int b = 0; b < 4; b++)
                if (m[4*e+b]) vr[32*e+8*b +: 8] = res[8*b +: 8];
            if (m[4*e]) c = top;
        end
        cr = c;
    endtask

    task automatic run_op(input logic [127:0] v, input logic [31:0] c, input logic [4:0] s,
                          input logic [3:0] r, input logic [15:0] m, input string tag);
        logic [127:0] ev;
        logic [31:0]  ec;
        bit           bad;
        bad = (r == 4'd13) || (r == 4'd15);
        if (bad) begin
            ev = v;
            ec = c;
        end else model(v, c, s, m, ev, ec);
        @(negedge clk);
        vin = v; cin = c; sh = s; idx = r; msk = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        vin = ~v; cin = ~c;
        chk(done == 1'b1, "R8 done", {127'd0, done}, 128'd1);
        chk(vout == ev, tag, vout, ev);
        chk(cout == ec, {tag, " R6 carry"}, {96'd0, cout}, {96'd0, ec});
        chk(illegal == bad, "R7 flag", {127'd0, illegal}, {127'd0, bad});
        @(negedge clk);
        chk(done == 1'b0 && vout == ev && cout == ec, "R8 hold", vout, ev);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] v;
        logic [31:0]  c;
        repeat (3) @(negedge clk);
        // R11: reset values
        chk(vout == '0 && cout == '0 && done == 1'b0 && illegal == 1'b0, "R11 reset", vout, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R11 idle", {127'd0, done}, '0);

        // R1: every nonzero shift with a full mask
        for (int s = 1; s < 32; s++)
            for (int p = 0; p < 3; p++)
                run_op(rnd128(), rnd(), 5'(s), 4'(p), 16'hFFFF, "R1 shift");

        // R2 / R3: only the gating bit of chosen lanes set or cleared
        for (int s = 0; s < 32; s++) begin
            run_op(rnd128(), rnd(), 5'(s), 4'd1, 16'h0001, "R2 lane0 gate");
            run_op(rnd128(), rnd(), 5'(s), 4'd2, 16'h1111, "R2 all gates");
            run_op(rnd128(), rnd(), 5'(s), 4'd3, 16'h1010, "R2 lanes1,3");
            run_op(rnd128(), rnd(), 5'(s), 4'd4, 16'hEEEE, "R3 gates clear");
            run_op(rnd128(), rnd(), 5'(s), 4'd5, 16'hFFEF, "R3 lane1 pass");
        end

        // R4: zero immediate with assorted masks
        for (int i = 0; i < 16; i++)
            run_op(rnd128(), rnd(), 5'd0, 4'd6, 16'(16'h1 << i) | 16'h0101, "R4 full-width");

        // R5: pseudo-random byte masks over all shifts
        for (int s = 0; s < 32; s++)
            for (int p = 0; p < 4; p++)
                run_op(rnd128(), rnd(), 5'(s), 4'd7, rnd() >> 16, "R5 merge");

        // R9: full rotate, expected by concatenation
        for (int i = 0; i < 8; i++) begin
            v = rnd128();
            c = rnd();
            @(negedge clk);
            vin = v; cin = c; sh = 5'd0; idx = 4'd8; msk = 16'hFFFF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(vout == {v[95:0], c}, "R9 rotate vec", vout, {v[95:0], c});
            chk(cout == v[127:96], "R9 rotate carry", {96'd0, cout}, {96'd0, v[127:96]});
        end

        // R10: empty mask leaves everything as it was
        for (int s = 0; s < 32; s++) begin
            v = rnd128();
            c = rnd();
            @(negedge clk);
            vin = v; cin = c; sh = 5'(s); idx = 4'd9; msk = 16'h0000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(vout == v && cout == c, "R10 empty mask", vout, v);
        end

        // R7: every register index
        for (int r = 0; r < 16; r++)
            run_op(rnd128(), rnd(), 5'(r + 3), 4'(r), 16'hFFFF, "R7 index");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule